// File: doc/BRIEF.md
# Time-Shared Quadratic Evaluator

This block evaluates y = A·x² + B·x + C on signed two's-complement operands. It has only one multiplier and one adder. A small step controller reuses both across several clock cycles. The multiplier squares x, then forms B·x, then forms A·x². The adder first adds C to B·x, then adds that stored partial sum to A·x². Operand selection multiplexers in front of the two units pick the operands for each step. Three working registers hold the intermediate values: the square of x, the partial sum and the result.

A caller drives x and the three coefficients, then pulses `start` while the block is not busy. The block captures x on the accepting edge. It reads the coefficients during the compute steps, so A, B and C must stay stable until `done`. The result is written on the final step, and `done` pulses for one cycle at the same moment. A new `start` may be given during that `done` cycle, which gives a full evaluation every four cycles. A `start` during the busy steps is dropped.

Top module: `quad_eval`

## Requirements
- R1: While `rst` is high at a rising edge, the block returns to idle, and afterwards `y` is 0, `done` is 0 and `busy` is 0.
- R2: A `start` sampled high while idle captures `x_in`. `busy` is then high for exactly the three cycles that follow the accepting edge.
- R3: `done` is high for exactly one cycle. It rises on the third rising edge after the edge that accepted `start`.
- R4: When `done` is high, `y` (width 3·W+1, signed) equals A·x² + B·x + C exactly. This holds for every signed W-bit x, A, B and C, including the most negative and most positive values.
- R5: `y` changes only on the edge that raises `done`, and otherwise holds its last result.
- R6: A `start` sampled while `busy` is high is ignored. It does not alter the running result, and it does not produce an extra `done`.
- R7: A `start` sampled during the `done` cycle is accepted at once, so back-to-back evaluations complete every four cycles.
- R8: `busy` and `done` are never high together, and `done` is high in every cycle in which `busy` has just fallen.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request an evaluation (honoured when idle or in the done cycle) |
| x_in | input | W | Signed variable x, captured on the accepting edge |
| coef_a | input | W | Signed coefficient of x², held stable until done |
| coef_b | input | W | Signed coefficient of x, held stable until done |
| coef_c | input | W | Signed constant term, held stable until done |
| y | output | 3·W+1 | Signed result register |
| done | output | 1 | One-cycle pulse when y has been written |
| busy | output | 1 | High during the three compute steps |

## Verification
The cycle-level rules are checked on every cycle by the properties:
- `done` never lasts longer than one cycle.
- Each `done` follows three busy cycles.
- `busy` and `done` never overlap.
- `y` never changes outside a `done` edge.
- x is loaded only when the block is not busy.
- No two working registers load in the same cycle.

Only the scenarios can show the remaining behaviour:
- that the arithmetic is exact at the signed extremes;
- that a mid-flight `start` leaves both the result and the `done` count untouched;
- that starts issued in the `done` cycle chain at a four-cycle period.

// File: rtl/quad_pkg.sv
package quad_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_SQ   = 3'd1,
    ST_BXC  = 3'd2,
    ST_FIN  = 3'd3,
    ST_DONE = 3'd4
  } step_t;

  typedef enum logic {
    PA_X  = 1'b0,
    PA_XX = 1'b1
  } pa_sel_t;

  typedef enum logic [1:0] {
    PB_X = 2'd0,
    PB_A = 2'd1,
    PB_B = 2'd2
  } pb_sel_t;

  typedef enum logic {
    AD_C   = 1'b0,
    AD_ACC = 1'b1
  } ad_sel_t;

  typedef struct packed {
    logic    ld_x;
    logic    ld_xx;
    logic    ld_bxc;
    logic    ld_y;
    pa_sel_t pa;
    pb_sel_t pb;
    ad_sel_t ad;
  } ctl_t;

endpackage

// File: rtl/quad_mul.sv
module quad_mul #(
  parameter int AW = 32,
  parameter int BW = 16,
  localparam int PW = AW + BW
) (
  input  logic signed [AW-1:0] a,
  input  logic signed [BW-1:0] b,
  output logic signed [PW-1:0] p
);
  // Full-precision signed product; the wider operand carries the square.
  generate
    if (AW >= BW) begin : g_wide_a
      assign p = a * b;
    end else begin : g_wide_b
      assign p = b * a;
    end
  endgenerate
endmodule

// File: rtl/quad_ctrl.sv
module quad_ctrl
  import quad_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start,
  output ctl_t ctl,
  output logic busy,
  output logic done
);
  step_t st, st_nx;

  always_comb begin
    ctl    = '0;
    ctl.pa = PA_X;
    ctl.pb = PB_X;
    ctl.ad = AD_C;
    st_nx  = st;
    case (st)
      ST_IDLE, ST_DONE: begin
        if (start) begin
          ctl.ld_x = 1'b1;
          st_nx    = ST_SQ;
        end else begin
          st_nx = ST_IDLE;
        end
      end
      ST_SQ: begin
        ctl.pa    = PA_X;
        ctl.pb    = PB_X;
        ctl.ld_xx = 1'b1;
        st_nx     = ST_BXC;
      end
      ST_BXC: begin
        ctl.pa     = PA_X;
        ctl.pb     = PB_B;
        ctl.ad     = AD_C;
        ctl.ld_bxc = 1'b1;
        st_nx      = ST_FIN;
      end
      ST_FIN: begin
        ctl.pa   = PA_XX;
        ctl.pb   = PB_A;
        ctl.ad   = AD_ACC;
        ctl.ld_y = 1'b1;
        st_nx    = ST_DONE;
      end
      default: st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= ST_IDLE;
      busy <= 1'b0;
      done <= 1'b0;
    end else begin
      st   <= st_nx;
      busy <= (st_nx == ST_SQ) || (st_nx == ST_BXC) || (st_nx == ST_FIN);
      done <= (st_nx == ST_DONE);
    end
  end
endmodule

// File: rtl/quad_datapath.sv
module quad_datapath
  import quad_pkg::*;
#(
  parameter int W = 16,
  localparam int XW = 2 * W,
  localparam int PW = 3 * W,
  localparam int YW = 3 * W + 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  ctl_t                 ctl,
  input  logic signed [W-1:0]  x_in,
  input  logic signed [W-1:0]  coef_a,
  input  logic signed [W-1:0]  coef_b,
  input  logic signed [W-1:0]  coef_c,
  output logic signed [YW-1:0] y_q
);
  logic signed [W-1:0]  x_q;
  logic signed [XW-1:0] xx_q;
  logic signed [YW-1:0] bxc_q;

  logic signed [XW-1:0] opa;
  logic signed [W-1:0]  opb;
  logic signed [PW-1:0] prod;
  logic signed [YW-1:0] prod_ext;
  logic signed [YW-1:0] addb;
  logic signed [YW-1:0] sum;

  // Port A steering: x (sign-extended) or the stored square.
  always_comb begin
    if (ctl.pa == PA_XX) opa = xx_q;
    else                 opa = {{(XW-W){x_q[W-1]}}, x_q};
  end

  // Port B steering: x, A or B.
  always_comb begin
    case (ctl.pb)
      PB_A:    opb = coef_a;
      PB_B:    opb = coef_b;
      default: opb = x_q;
    endcase
  end

  quad_mul #(.AW(XW), .BW(W)) u_mul (
    .a (opa),
    .b (opb),
    .p (prod)
  );

  assign prod_ext = {{(YW-PW){prod[PW-1]}}, prod};

  // Second adder input: constant term or the stored partial sum.
  always_comb begin
    if (ctl.ad == AD_ACC) addb = bxc_q;
    else                  addb = {{(YW-W){coef_c[W-1]}}, coef_c};
  end

  assign sum = prod_ext + addb;

  always_ff @(posedge clk) begin
    if (rst) begin
      x_q   <= '0;
      xx_q  <= '0;
      bxc_q <= '0;
      y_q   <= '0;
    end else begin
      if (ctl.ld_x)   x_q   <= x_in;
      if (ctl.ld_xx)  xx_q  <= prod[XW-1:0];
      if (ctl.ld_bxc) bxc_q <= sum;
      if (ctl.ld_y)   y_q   <= sum;
    end
  end
endmodule

// File: rtl/quad_eval.sv
module quad_eval
  import quad_pkg::*;
#(
  parameter int W = 16,
  localparam int YW = 3 * W + 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic signed [W-1:0]  x_in,
  input  logic signed [W-1:0]  coef_a,
  input  logic signed [W-1:0]  coef_b,
  input  logic signed [W-1:0]  coef_c,
  output logic signed [YW-1:0] y,
  output logic                 done,
  output logic                 busy
);
  ctl_t ctl;

  quad_ctrl u_ctrl (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .ctl   (ctl),
    .busy  (busy),
    .done  (done)
  );

  quad_datapath #(.W(W)) u_dp (
    .clk    (clk),
    .rst    (rst),
    .ctl    (ctl),
    .x_in   (x_in),
    .coef_a (coef_a),
    .coef_b (coef_b),
    .coef_c (coef_c),
    .y_q    (y)
  );
endmodule

// File: rtl/quad_eval_chk.sv
module quad_eval_chk #(
  parameter int YW = 49
) (
  input logic          clk,
  input logic          rst,
  input logic          done,
  input logic          busy,
  input logic [3:0]    loads,
  input logic [YW-1:0] y
);
  // R3: done is a single-cycle pulse
  p_done_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R3: done is preceded by exactly the three busy steps
  p_done_after_busy_r3: assert property (@(posedge clk) disable iff (rst)
    done |-> ($past(busy, 1) && $past(busy, 2) && $past(busy, 3)));

  // R5: result changes only with done
  p_y_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !$stable(y) |-> done);

  // R8: busy and done exclusive
  p_excl_r8: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R8: busy ends with done
  p_fall_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  // R6: x is captured only outside the busy steps
  p_ignore_busy_r6: assert property (@(posedge clk) disable iff (rst)
    loads[3] |-> !busy);

  // R4: at most one working register written per step
  p_one_load_r4: assert property (@(posedge clk) disable iff (rst)
    $onehot0(loads));
endmodule

bind quad_eval quad_eval_chk #(.YW(3 * W + 1)) u_chk (
  .clk   (clk),
  .rst   (rst),
  .done  (done),
  .busy  (busy),
  .loads ({ctl.ld_x, ctl.ld_xx, ctl.ld_bxc, ctl.ld_y}),
  .y     (y)
);

// File: tb/test_quad_eval.sv
module test_quad_eval;
  localparam int W  = 16;
  localparam int YW = 3 * W + 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic signed [W-1:0] x_in = '0, ca = '0, cb = '0, cc = '0;
  logic signed [YW-1:0] y;
  logic done, busy;

  int n_cmp = 0;
  int n_bad = 0;
  int unsigned cyc = 0;
  bit finished = 1'b0;

  typedef struct {
    longint      yv;
    int unsigned due;
    string       tag;
  } exp_t;
  exp_t sb[$];
  exp_t e_cur;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  quad_eval #(.W(W)) i_quad_eval (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .x_in   (x_in),
    .coef_a (ca),
    .coef_b (cb),
    .coef_c (cc),
    .y      (y),
    .done   (done),
    .busy   (busy)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  function automatic longint model(input longint x, input longint a, input longint b, input longint c);
    return a * x * x + b * x + c;
  endfunction

  // Driver: called at a falling edge; returns at the falling edge of the done cycle.
  task automatic launch(input logic signed [W-1:0] x, input logic signed [W-1:0] a,
                        input logic signed [W-1:0] b, input logic signed [W-1:0] c,
                        input string tag);
    x_in = x; ca = a; cb = b; cc = c; start = 1'b1;
    sb.push_back('{model(x, a, b, c), cyc + 4, tag});
    @(negedge clk) start = 1'b0;
    chk(busy == 1'b1, "R2 busy step 1", busy, 1);
    @(negedge clk);
    chk(busy == 1'b1, "R2 busy step 2", busy, 1);
    @(negedge clk);
    chk(busy == 1'b1, "R2 busy step 3", busy, 1);
    @(negedge clk);
    chk(busy == 1'b0 && done == 1'b1, "R8 busy low with done", {busy, done}, 1);
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (!rst && !finished) begin
      if (done) begin
        if (sb.size() == 0) begin
          chk(1'b0, "R6 unexpected done", 1, 0);
        end else begin
          e_cur = sb.pop_front();
          chk(longint'(y) == e_cur.yv, {e_cur.tag, " result"}, longint'(y), e_cur.yv);
          chk(cyc == e_cur.due, {e_cur.tag, " R3 done timing"}, longint'(cyc), longint'(e_cur.due));
        end
      end else if (sb.size() > 0 && cyc >= sb[0].due) begin
        chk(1'b0, "R3 done missing", 0, 1);
        void'(sb.pop_front());
      end
    end
  end

  initial begin
    logic signed [W-1:0] rx, ra, rb, rc;
    logic signed [YW-1:0] held;

    repeat (3) @(negedge clk);
    chk(y == '0, "R1 reset y", longint'(y), 0);
    chk(done == 1'b0, "R1 reset done", done, 0);
    chk(busy == 1'b0, "R1 reset busy", busy, 0);
    rst = 1'b0;
    @(negedge clk);

    launch(16'sd3, 16'sd2, 16'sd5, 16'sd7, "R4 small");
    repeat (2) @(negedge clk);
    launch(-16'sd32768, -16'sd32768, -16'sd32768, -16'sd32768, "R4 all min");
    @(negedge clk);
    launch(16'sd32767, 16'sd32767, 16'sd32767, 16'sd32767, "R4 all max");
    @(negedge clk);
    launch(-16'sd32768, 16'sd32767, -16'sd32768, 16'sd32767, "R4 mixed extreme");
    @(negedge clk);
    launch(-16'sd32768, -16'sd32768, 16'sd32767, -16'sd32768, "R4 neg square");
    @(negedge clk);
    launch(16'sd0, 16'sd1234, -16'sd77, -16'sd5, "R4 x zero");
    @(negedge clk);

    for (int i = 0; i < 40; i++) begin
      rx = W'($urandom); ra = W'($urandom); rb = W'($urandom); rc = W'($urandom);
      launch(rx, ra, rb, rc, "R4 random");
      repeat ($urandom_range(0, 2)) @(negedge clk);
    end

    // R5: result holds after done while idle
    @(negedge clk);
    held = y;
    repeat (5) @(negedge clk);
    chk(y == held, "R5 y hold idle", longint'(y), longint'(held));

    // R6: start during busy is ignored
    x_in = 16'sd11; ca = -16'sd3; cb = 16'sd9; cc = 16'sd100; start = 1'b1;
    sb.push_back('{model(11, -3, 9, 100), cyc + 4, "R6 busy start"});
    @(negedge clk) start = 1'b0;
    @(negedge clk);
    x_in = -16'sd2000; start = 1'b1;
    @(negedge clk) start = 1'b0;
    @(negedge clk);
    chk(done == 1'b1, "R6 done once", done, 1);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk(done == 1'b0, "R6 no extra done", done, 0);
    end

    // R7: back-to-back starts in the done cycle
    @(negedge clk);
    for (int i = 0; i < 6; i++) begin
      rx = W'($urandom); ra = W'($urandom); rb = W'($urandom); rc = W'($urandom);
      launch(rx, ra, rb, rc, "R7 back-to-back");
    end
    // R5: y holds after the last done
    held = y;
    repeat (4) @(negedge clk);
    chk(y == held, "R5 y hold after chain", longint'(y), longint'(held));
    chk(sb.size() == 0, "R3 scoreboard drained", sb.size(), 0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule